// File: doc/BRIEF.md
# Trace Security Sideband Generator

This block drives, for every hart, the two sideband lines that tell a trace encoder whether it may emit trace. A security line says that trace output is withheld because of the debug security policy. A halted line says that the hart is stopped. The decision for each hart takes four inputs: a machine-level trace enable pin, a submachine trace-allow bit held in a configuration register elsewhere, the hart's current privilege level, and its real halted status.

Trace is withheld from reset. It is released at every privilege level when the machine enable is set. When only the submachine allow bit is set, it is released outside machine mode. A single configuration input tells the block whether the encoder understands the security line. When it does not, the block signals the same withholding on the halted line instead. The two lines are never high together, because that combination is reserved.

Both outputs are registered and follow their inputs with one clock of latency. Each hart has its own lane, built by a generate loop, and no state is shared between lanes.

Top module: `trcsec_gate`

## Requirements
- R1: While reset is asserted and at the first edge after it, each hart shows sec_block=1 and trc_halted=0 if enc_sec_sup is 1. If enc_sec_sup is 0, each hart shows sec_block=0 and trc_halted=1.
- R2: With mach_trc_en=1 and the hart not halted, both outputs are 0 at every privilege code.
- R3: With mach_trc_en=0 and sub_trc_allow=1, trace is withheld when the privilege code equals machine mode (2'b11). It is released for every other code: 2'b00 user, 2'b01 supervisor, and 2'b10, which is treated as submachine.
- R4: With mach_trc_en=0 and sub_trc_allow=0, trace is withheld at every privilege code.
- R5: sec_block and trc_halted are never both 1 for the same hart.
- R6: With enc_sec_sup=1, withholding is shown as sec_block=1, trc_halted=0. With enc_sec_sup=0, it is shown as sec_block=0, trc_halted=1.
- R7: When hart_halted is 1, that hart's outputs are trc_halted=1 and sec_block=0, whatever the trace controls are.
- R8: The outputs reflect the inputs sampled at the previous rising clock edge, and each hart's outputs depend only on that hart's inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_sec_sup | input | 1 | 1 when the encoder accepts the security line; quasi-static |
| mach_trc_en | input | NHARTS | Machine trace enable, one bit per hart |
| sub_trc_allow | input | NHARTS | Submachine trace-allow control bit, one per hart |
| priv_lvl | input | NHARTS*PRIV_W | Current privilege code per hart; hart h uses bits [h*PRIV_W +: PRIV_W] |
| hart_halted | input | NHARTS | Real halted status per hart |
| sec_block | output | NHARTS | Security withholding line to the encoder |
| trc_halted | output | NHARTS | Halted line to the encoder |

## Verification
A wrong lane register would show at that hart's output pair on the very next edge after the inputs that expose it. Examples are an inverted privilege compare, a lost override by the halted status, or a wrong choice of fallback line. Every pair is compared against a reference each cycle, so such a fault shows up within one clock of the triggering input pattern. A wrong reset value shows up before reset is released. Leakage between harts appears as a mismatch on a lane whose own inputs did not call for the observed value.

// File: rtl/trcsec_pkg.sv
package trcsec_pkg;

   // Pair of sideband lines presented to the trace encoder.
   typedef struct packed {
      logic sec;    // trace withheld for security
      logic halt;   // hart reported as halted
   } trc_side_t;

   // Value a lane holds while reset is active.
   function automatic trc_side_t side_at_reset(input logic sup);
      trc_side_t s;
      s.sec  = sup;
      s.halt = ~sup;
      return s;
   endfunction

endpackage

// File: rtl/trcsec_policy.sv
// Decides, for one hart, whether trace must be withheld at its privilege.
module trcsec_policy #(
   parameter int            PRIV_W    = 2,
   parameter logic [PRIV_W-1:0] MACH_CODE = '1,
   parameter bit            EXACT_CMP = 1'b1
) (
   input  logic              mach_en,
   input  logic              sub_allow,
   input  logic [PRIV_W-1:0] priv,
   output logic              shut
);
   logic in_mach;

   generate
      if (EXACT_CMP) begin : g_exact
         assign in_mach = (priv == MACH_CODE);
      end else begin : g_top
         // Any code at or above the machine code counts as machine level.
         assign in_mach = (priv >= MACH_CODE);
      end
   endgenerate

   // Released by the machine enable anywhere, by the submachine bit below M.
   assign shut = ~(mach_en | (sub_allow & ~in_mach));
endmodule

// File: rtl/trcsec_encode.sv
// Maps the withholding decision onto the two encoder lines.
module trcsec_encode
   import trcsec_pkg::*;
(
   input  logic      shut,
   input  logic      hart_halted,
   input  logic      sup,
   output trc_side_t side
);
   always_comb begin
      side = '0;
      if (hart_halted) begin
         side.halt = 1'b1;
      end else if (sup) begin
         side.sec = shut;
      end else begin
         side.halt = shut;
      end
   end
endmodule

// File: rtl/trcsec_lane.sv
// One hart: decision, encoding and output register.
module trcsec_lane
   import trcsec_pkg::*;
#(
   parameter int            PRIV_W    = 2,
   parameter logic [PRIV_W-1:0] MACH_CODE = '1,
   parameter bit            EXACT_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sup,
   input  logic              mach_en,
   input  logic              sub_allow,
   input  logic [PRIV_W-1:0] priv,
   input  logic              hart_halted,
   output logic              sec_o,
   output logic              halt_o
);
   logic      shut;
   trc_side_t side_d, side_q;

   trcsec_policy #(
      .PRIV_W   (PRIV_W),
      .MACH_CODE(MACH_CODE),
      .EXACT_CMP(EXACT_CMP)
   ) u_policy (
      .mach_en  (mach_en),
      .sub_allow(sub_allow),
      .priv     (priv),
      .shut     (shut)
   );

   trcsec_encode u_encode (
      .shut       (shut),
      .hart_halted(hart_halted),
      .sup        (sup),
      .side       (side_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) side_q <= side_at_reset(sup);
      else        side_q <= side_d;
   end

   assign sec_o  = side_q.sec;
   assign halt_o = side_q.halt;

   // R5: reserved combination never produced
   p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(sec_o && halt_o));

   // R7: real halt overrides the trace controls
   p_halt_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hart_halted |=> (halt_o && !sec_o));

   // R2: machine enable releases trace at every privilege
   p_mach_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mach_en && !hart_halted) |=> (!sec_o && !halt_o));

   // R4: with both controls clear, trace stays withheld
   p_all_shut_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mach_en && !sub_allow && !hart_halted) |=> (sec_o || halt_o));

   // R6: without encoder support the security line stays low
   p_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !sup |=> !sec_o);
endmodule

// File: rtl/trcsec_gate.sv
// Top: one trace security lane per hart.
module trcsec_gate #(
   parameter int            NHARTS    = 4,
   parameter int            PRIV_W    = 2,
   parameter logic [PRIV_W-1:0] MACH_CODE = '1,
   parameter bit            EXACT_CMP = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enc_sec_sup,
   input  logic [NHARTS-1:0]        mach_trc_en,
   input  logic [NHARTS-1:0]        sub_trc_allow,
   input  logic [NHARTS*PRIV_W-1:0] priv_lvl,
   input  logic [NHARTS-1:0]        hart_halted,
   output logic [NHARTS-1:0]        sec_block,
   output logic [NHARTS-1:0]        trc_halted
);
   localparam int NCODES = 1 << PRIV_W;

   generate
      if (NHARTS < 1) begin : g_bad_nharts
         $error("trcsec_gate: NHARTS must be at least 1");
      end
      if (PRIV_W < 1 || PRIV_W > 8) begin : g_bad_privw
         $error("trcsec_gate: PRIV_W must lie in 1..8");
      end
      if (int'(MACH_CODE) >= NCODES) begin : g_bad_mcode
         $error("trcsec_gate: MACH_CODE outside privilege code space");
      end
   endgenerate

   for (genvar h = 0; h < NHARTS; h++) begin : g_lane
      trcsec_lane #(
         .PRIV_W   (PRIV_W),
         .MACH_CODE(MACH_CODE),
         .EXACT_CMP(EXACT_CMP)
      ) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .sup        (enc_sec_sup),
         .mach_en    (mach_trc_en[h]),
         .sub_allow  (sub_trc_allow[h]),
         .priv       (priv_lvl[h*PRIV_W +: PRIV_W]),
         .hart_halted(hart_halted[h]),
         .sec_o      (sec_block[h]),
         .halt_o     (trc_halted[h])
      );
   end
endmodule

// File: tb/sim_trcsec_gate.sv
module sim_trcsec_gate;
   localparam int NH = 4;
   localparam int PW = 2;
   localparam logic [1:0] MCODE = 2'b11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sup = 1'b1;
   logic [NH-1:0] men = '0, sal = '0, hh = '0;
   logic [NH*PW-1:0] pl = '1;
   logic [NH-1:0] sec, thl;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   trcsec_gate #(.NHARTS(NH), .PRIV_W(PW)) u0 (
      .clk(clk), .rst_n(rst_n), .enc_sec_sup(sup),
      .mach_trc_en(men), .sub_trc_allow(sal), .priv_lvl(pl),
      .hart_halted(hh), .sec_block(sec), .trc_halted(thl)
   );

   // Reference from the requirements: returns {sec, halt}.
   function automatic logic [1:0] model(logic m, logic s, logic [1:0] p,
                                        logic h, logic su);
      logic shut;
      if (h) return 2'b01;                       // R7
      shut = !(m || (s && p != MCODE));          // R2 R3 R4
      return su ? {shut, 1'b0} : {1'b0, shut};   // R6
   endfunction

   function automatic string tag_of(logic m, logic s, logic h, logic su);
      if (h)   return "R7";
      if (!su) return "R6";
      if (m)   return "R2";
      if (s)   return "R3";
      return "R4";
   endfunction

   task automatic chk(string tag, int h, logic [1:0] act, logic [1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s hart %0d: sec/halt actual=%b expected=%b", tag, h, act, exp);
      end
   endtask

   task automatic check_all();
      for (int h = 0; h < NH; h++) begin
         chk(tag_of(men[h], sal[h], hh[h], sup), h, {sec[h], thl[h]},
             model(men[h], sal[h], pl[h*PW +: PW], hh[h], sup));
         total++;
         if (sec[h] && thl[h]) begin
            bad++;
            $display("FAIL R5 hart %0d: actual=11 expected=not 11", h);
         end
      end
   endtask

   // Inputs already driven at a negedge; check after the next edge.
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      check_all();
   endtask

   task automatic randomize_in(bit vary_sup);
      men = NH'($urandom);
      sal = NH'($urandom);
      hh  = NH'($urandom & $urandom);
      pl  = (NH*PW)'($urandom);
      if (vary_sup && ($urandom % 8 == 0)) sup = ~sup;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [1:0] prev [NH];
      void'($urandom(32'h1d3a_5eed));
      // R1: reset values with encoder support
      repeat (3) @(negedge clk);
      for (int h = 0; h < NH; h++) chk("R1", h, {sec[h], thl[h]}, 2'b10);
      rst_n = 1'b1;
      step();   // all controls 0, machine mode: still withheld
      for (int h = 0; h < NH; h++) chk("R1", h, {sec[h], thl[h]}, 2'b10);

      // R2: machine enable at every privilege code
      men = '1; pl = {2'b11, 2'b10, 2'b01, 2'b00};
      step();
      // R3: submachine allow only; one hart per code
      men = '0; sal = '1;
      step();
      for (int h = 0; h < NH; h++)
         chk("R3", h, {sec[h], thl[h]}, (h == 3) ? 2'b10 : 2'b00);
      // R4: both clear at every code
      sal = '0;
      step();
      for (int h = 0; h < NH; h++) chk("R4", h, {sec[h], thl[h]}, 2'b10);
      // R7: halted overrides enable and withholding
      hh = 4'b0101; men = 4'b0001;
      step();
      hh = '0;

      // R8: output holds until the edge, then follows; lanes independent
      men = 4'b0000; sal = '0; pl = '1;
      step();
      for (int h = 0; h < NH; h++) prev[h] = {sec[h], thl[h]};
      men = 4'b0010;
      #1;
      for (int h = 0; h < NH; h++) chk("R8", h, {sec[h], thl[h]}, prev[h]);
      step();
      for (int h = 0; h < NH; h++)
         chk("R8", h, {sec[h], thl[h]}, (h == 1) ? 2'b00 : 2'b10);

      // Random with support
      for (int i = 0; i < 3000; i++) begin
         randomize_in(1'b0);
         step();
      end

      // R1: reset values without encoder support
      rst_n = 1'b0; sup = 1'b0;
      men = '1;
      repeat (2) @(negedge clk);
      for (int h = 0; h < NH; h++) chk("R1", h, {sec[h], thl[h]}, 2'b01);
      rst_n = 1'b1;

      // R6: fallback with machine mode withheld
      men = '0; sal = '1; hh = '0; pl = {2'b11, 2'b00, 2'b11, 2'b01};
      step();
      for (int h = 0; h < NH; h++)
         chk("R6", h, {sec[h], thl[h]}, (h == 1 || h == 3) ? 2'b01 : 2'b00);

      // Random with the support flag also changing
      for (int i = 0; i < 3000; i++) begin
         randomize_in(1'b1);
         step();
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule